// File: doc/BRIEF.md
# HDLC Receive FIFO with DMA Byte Requests

This block is the receive buffer of a byte-oriented HDLC data link channel, seen from an external DMA engine. A deframer upstream delivers frame bytes on a valid/ready stream. The final beat of each frame is marked and carries the frame's abort and CRC-error flags. The block stores the bytes in a small FIFO and places one status byte behind the last data byte of each frame. While the FIFO holds anything, it requests one DMA read per byte. The DMA engine drains the bytes, and the status byte last, through the data address of a small register port.

Once the DMA engine has read a status byte, the block raises an end-of-message output. It then keeps the channel closed until the host reads the status address. That read returns the frame's status byte, clears the end-of-message output and lets the next frame in.

Input stream rules: a beat transfers on a rising edge where `in_valid` and `in_ready` are both high. The source must hold the beat stable until it transfers. `in_ready` depends only on internal state and configuration, never on `in_valid`. The block applies back-pressure in three cases: while the channel is disabled, in the cycle after a frame's last beat while the status byte is written, and while a finished frame waits for release.

Top module: `frm_rx_dma`

## Requirements
- R1: `in_ready` and `dma_rd_req` can be high only while configuration bit 0 (receiver enable) and bit 1 (DMA enable) are both set. A write to address 0 sets these bits from `reg_wdata[1:0]`. A read of address 0 returns them in `reg_rdata[1:0]`, with the upper bits zero.
- R2: A beat is stored only when `in_valid && in_ready`. `in_ready` stays low from the edge that takes a frame's last beat until that frame is released.
- R3: `dma_rd_req` is high whenever the channel is enabled and the FIFO holds at least one entry. It falls at the edge where a read removes the only entry and nothing is written.
- R4: A read of address 1 removes one entry, oldest first. Its byte appears on `reg_rdata` after the edge that takes the read strobe.
- R5: On the edge after a frame's last beat is stored, exactly one status byte is appended. Its bit 0 is the CRC-error flag, bit 1 the abort flag, bit 2 the overflow flag, and bits 7..3 are zero.
- R6: `msg_end` rises on the edge at which a status byte is read out through address 1. It stays high until it is released as described in R7.
- R7: A read of address 2 returns the last status byte delivered. If `msg_end` is high and the frame's tail has been fully received, the read also clears `msg_end` and reopens the input. Otherwise the read has no side effect.
- R8: The FIFO holds DEPTH entries, and one of them is always kept free for the status byte. A beat arriving while DEPTH-1 entries are occupied is not stored. In its place the status byte 0x04 (overflow only) is appended. The remaining beats of that frame are accepted and discarded up to its last beat, and the flags on that last beat are ignored.
- R9: A read of address 1 while the FIFO is empty returns zero and changes no state.
- R10: After reset, `in_ready`, `dma_rd_req`, `msg_end`, `reg_rdata` and both configuration bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Frame byte valid |
| in_ready | output | 1 | Block can take a frame byte |
| in_data | input | DW | Frame byte |
| in_last | input | 1 | Beat is the last of its frame |
| in_abort | input | 1 | Frame aborted (sampled with `in_last`) |
| in_crc_err | input | 1 | Frame CRC failed (sampled with `in_last`) |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 configuration, 1 FIFO data, 2 status |
| reg_wdata | input | 2 | Configuration write value |
| reg_rdata | output | DW | Registered read data |
| dma_rd_req | output | 1 | DMA read request, one byte per read |
| msg_end | output | 1 | Status byte of a frame has been read |

## Verification
`in_ready` and `dma_rd_req` are functions of registered state, so they change only just after the edge that updates that state. Read data and `msg_end` are due one edge after their read strobe. A status byte enters the FIFO one edge after its frame's last beat.

The bench keeps a behavioural model built from queues. It updates the model on each rising edge from the same inputs the design sees. It compares all four outputs on every falling edge, where every one of these results has settled. Directed reads compare the returned bytes with constants worked out from the requirements.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam logic [1:0] ADDR_CFG  = 2'd0;
  localparam logic [1:0] ADDR_DATA = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  localparam int ST_CRC = 0;
  localparam int ST_ABT = 1;
  localparam int ST_OVF = 2;

  typedef enum logic [1:0] {
    FS_RECV = 2'd0,
    FS_STAT = 2'd1,
    FS_DROP = 2'd2,
    FS_HOLD = 2'd3
  } fstate_t;

  function automatic logic [7:0] mk_status(input logic crc, input logic abt, input logic ovf);
    logic [7:0] s;
    s = '0;
    s[ST_CRC] = crc;
    s[ST_ABT] = abt;
    s[ST_OVF] = ovf;
    return s;
  endfunction
endpackage

// File: rtl/rxd_fifo.sv
module rxd_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_word,
  input  logic          rd_en,
  output logic [W-1:0]  rd_word,
  output logic [CW-1:0] count,
  output logic          empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          full;

  assign rd_word = mem[rp];
  assign count   = cnt;
  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_en) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (rd_en) rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R8
  fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full);

  // R4
  fifo_count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en) |=> (cnt == $past(cnt) + CW'(1)));
endmodule

// File: rtl/rxd_frame_ctl.sv
module rxd_frame_ctl
  import rxd_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_last,
  input  logic          in_abort,
  input  logic          in_crc_err,
  input  logic [CW-1:0] fifo_count,
  input  logic          release_i,
  output logic          in_ready,
  output logic          wr_en,
  output logic [DW:0]   wr_word,
  output logic          held
);
  fstate_t       st;
  logic [DW-1:0] pend_stat;
  logic          accept;
  logic          room;

  assign room     = (fifo_count < CW'(DEPTH-1));
  assign in_ready = en && ((st == FS_RECV) || (st == FS_DROP));
  assign accept   = in_valid && in_ready;
  assign held     = (st == FS_HOLD);

  always_comb begin
    wr_en   = 1'b0;
    wr_word = '0;
    case (st)
      FS_RECV: begin
        if (accept) begin
          wr_en = 1'b1;
          if (room) wr_word = {1'b0, in_data};
          else      wr_word = {1'b1, DW'(mk_status(1'b0, 1'b0, 1'b1))};
        end
      end
      FS_STAT: begin
        wr_en   = 1'b1;
        wr_word = {1'b1, pend_stat};
      end
      default: begin
        wr_en   = 1'b0;
        wr_word = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= FS_RECV;
      pend_stat <= '0;
    end else begin
      case (st)
        FS_RECV: begin
          if (accept) begin
            if (!room) begin
              st <= in_last ? FS_HOLD : FS_DROP;
            end else if (in_last) begin
              pend_stat <= DW'(mk_status(in_crc_err, in_abort, 1'b0));
              st        <= FS_STAT;
            end
          end
        end
        FS_STAT: st <= FS_HOLD;
        FS_DROP: if (accept && in_last) st <= FS_HOLD;
        FS_HOLD: if (release_i) st <= FS_RECV;
        default: st <= FS_RECV;
      endcase
    end
  end

  // R5
  stat_follows_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FS_RECV && accept && in_last && room) |=> (wr_en && wr_word[DW]));

  // R2
  hold_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !release_i) |=> !in_ready);
endmodule

// File: rtl/rxd_regs.sv
module rxd_regs
  import rxd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_rd,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [1:0]    reg_wdata,
  input  logic          fifo_empty,
  input  logic [DW:0]   head_word,
  input  logic          held,
  output logic          pop,
  output logic [DW-1:0] reg_rdata,
  output logic          rme,
  output logic          en,
  output logic          release_o
);
  logic [1:0]    cfg;
  logic [DW-1:0] stat_q;
  logic          data_rd, stat_rd;

  assign data_rd   = reg_rd && (reg_addr == ADDR_DATA);
  assign stat_rd   = reg_rd && (reg_addr == ADDR_STAT);
  assign pop       = data_rd && !fifo_empty;
  assign release_o = stat_rd && rme && held;
  assign en        = cfg[0] && cfg[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg       <= '0;
      stat_q    <= '0;
      rme       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr && (reg_addr == ADDR_CFG)) cfg <= reg_wdata;
      if (pop && head_word[DW]) begin
        rme    <= 1'b1;
        stat_q <= head_word[DW-1:0];
      end else if (release_o) begin
        rme <= 1'b0;
      end
      if (reg_rd) begin
        case (reg_addr)
          ADDR_CFG:  reg_rdata <= {{(DW-2){1'b0}}, cfg};
          ADDR_DATA: reg_rdata <= pop ? head_word[DW-1:0] : '0;
          ADDR_STAT: reg_rdata <= stat_q;
          default:   reg_rdata <= '0;
        endcase
      end
    end
  end

  // R6
  rme_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && head_word[DW]) |=> rme);

  // R7
  rme_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rme && !release_o) |=> rme);
endmodule

// File: rtl/frm_rx_dma.sv
module frm_rx_dma #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_last,
  input  logic          in_abort,
  input  logic          in_crc_err,
  input  logic          reg_rd,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [1:0]    reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          dma_rd_req,
  output logic          msg_end
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = DW + 1;

  logic          en, pop, wr_en, held, release_w, fifo_empty;
  logic [DW:0]   wr_word, head_word;
  logic [CW-1:0] fifo_count;

  rxd_fifo #(.W(EW), .DEPTH(DEPTH), .CW(CW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
    .rd_en(pop), .rd_word(head_word), .count(fifo_count), .empty(fifo_empty)
  );

  rxd_frame_ctl #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_ctl (
    .clk(clk), .rst_n(rst_n), .en(en), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_abort(in_abort), .in_crc_err(in_crc_err),
    .fifo_count(fifo_count), .release_i(release_w), .in_ready(in_ready),
    .wr_en(wr_en), .wr_word(wr_word), .held(held)
  );

  rxd_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .fifo_empty(fifo_empty),
    .head_word(head_word), .held(held), .pop(pop), .reg_rdata(reg_rdata),
    .rme(msg_end), .en(en), .release_o(release_w)
  );

  assign dma_rd_req = en && !fifo_empty;

  // R3
  drr_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_rd_req && pop && (fifo_count == CW'(1)) && !wr_en) |=> !dma_rd_req);

  // R1
  drr_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_rd_req || in_ready) |-> en);
endmodule

// File: tb/frm_rx_dma_tb_top.sv
`timescale 1ns/1ps
module frm_rx_dma_tb_top;
  localparam int DW = 8;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, in_abort = 1'b0, in_crc_err = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic reg_rd = 1'b0, reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0, reg_wdata = 2'd0;
  logic in_ready, dma_rd_req, msg_end;
  logic [DW-1:0] reg_rdata;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  frm_rx_dma #(.DW(DW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .in_abort(in_abort),
    .in_crc_err(in_crc_err), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dma_rd_req(dma_rd_req), .msg_end(msg_end)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_q[$];
  int m_st = 0;
  int m_cfg = 0, m_stat = 0, m_rdata = 0, m_pend = 0;
  bit m_rme = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_q.delete();
      m_st = 0; m_cfg = 0; m_stat = 0; m_rdata = 0; m_pend = 0; m_rme = 1'b0;
    end else begin
      automatic int sz = m_q.size();
      automatic bit rdy = (m_cfg == 3) && (m_st == 0 || m_st == 2);
      automatic bit acc = in_valid && rdy;
      automatic int nst = m_st;
      if (reg_rd) begin
        case (reg_addr)
          2'd0: m_rdata = m_cfg;
          2'd1: begin
            if (sz > 0) begin
              automatic int w = m_q.pop_front();
              m_rdata = w & 255;
              if (w >= 256) begin m_rme = 1'b1; m_stat = w & 255; end
            end else m_rdata = 0;
          end
          2'd2: begin
            m_rdata = m_stat;
            if (m_rme && m_st == 3) begin m_rme = 1'b0; nst = 0; end
          end
          default: m_rdata = 0;
        endcase
      end
      if (reg_wr && reg_addr == 2'd0) m_cfg = reg_wdata;
      case (m_st)
        0: if (acc) begin
          if (sz < DEPTH - 1) begin
            m_q.push_back(in_data);
            if (in_last) begin
              m_pend = (in_crc_err ? 1 : 0) + (in_abort ? 2 : 0);
              nst = 1;
            end
          end else begin
            m_q.push_back(256 | 4);
            nst = in_last ? 3 : 2;
          end
        end
        1: begin m_q.push_back(256 | m_pend); nst = 3; end
        2: if (acc && in_last) nst = 3;
        default: ;
      endcase
      m_st = nst;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      automatic bit e_rdy = (m_cfg == 3) && (m_st == 0 || m_st == 2);
      automatic bit e_drr = (m_cfg == 3) && (m_q.size() > 0);
      check(in_ready === e_rdy, "R2 in_ready", in_ready, e_rdy);
      check(dma_rd_req === e_drr, "R3 dma_rd_req", dma_rd_req, e_drr);
      check(msg_end === m_rme, "R6 msg_end", msg_end, m_rme);
      check(reg_rdata === DW'(m_rdata), "R4 reg_rdata", reg_rdata, m_rdata);
    end
  end

  // all tasks start and end 1 ns after a falling edge
  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic write_cfg(input logic [1:0] v);
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = v;
    @(negedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic read_reg(input logic [1:0] a, output int v);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
    #1;
    reg_rd = 1'b0;
  endtask

  task automatic send_byte(input int d, input bit last, input bit ab, input bit crc);
    in_valid = 1'b1; in_data = DW'(d); in_last = last; in_abort = ab; in_crc_err = crc;
    #1;
    while (!in_ready) begin @(negedge clk); #2; end
    @(negedge clk); #1;
    in_valid = 1'b0; in_last = 1'b0; in_abort = 1'b0; in_crc_err = 1'b0;
  endtask

  task automatic send_frame(input int n, input int base, input bit ab, input bit crc);
    for (int i = 0; i < n; i++) send_byte(base + i, i == n - 1, ab, crc);
  endtask

  task automatic drain(input int n, input int base, input int stat, input string tag);
    int v;
    for (int i = 0; i < n; i++) begin
      read_reg(2'd1, v);
      check(v == base + i, {tag, " data byte"}, v, base + i);
    end
    read_reg(2'd1, v);
    check(v == stat, {tag, " status byte"}, v, stat);
    check(msg_end === 1'b1, "R6 end of message raised", msg_end, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(in_ready === 1'b0, "R10 in_ready", in_ready, 0);
    check(dma_rd_req === 1'b0, "R10 dma_rd_req", dma_rd_req, 0);
    check(msg_end === 1'b0, "R10 msg_end", msg_end, 0);
    check(reg_rdata === '0, "R10 reg_rdata", reg_rdata, 0);
    #1 rst_n = 1'b1;
    idle(1);
    read_reg(2'd0, v);
    check(v == 0, "R10 cfg after reset", v, 0);

    // R1 only one enable bit
    write_cfg(2'b01);
    in_valid = 1'b1; in_data = 8'hAA;
    idle(2);
    check(in_ready === 1'b0, "R1 ready with dma disabled", in_ready, 0);
    in_valid = 1'b0;
    read_reg(2'd0, v);
    check(v == 1, "R1 cfg readback", v, 1);
    write_cfg(2'b11);
    check(in_ready === 1'b1, "R1 ready when both enabled", in_ready, 1);

    // frame A: plain
    send_frame(4, 8'h10, 1'b0, 1'b0);
    idle(2);
    check(dma_rd_req === 1'b1, "R3 request with data", dma_rd_req, 1);
    check(in_ready === 1'b0, "R2 held frame blocks input", in_ready, 0);
    drain(4, 8'h10, 8'h00, "R5 frame A");
    check(dma_rd_req === 1'b0, "R3 request drops when empty", dma_rd_req, 0);
    read_reg(2'd1, v);
    check(v == 0, "R9 empty read returns zero", v, 0);
    check(msg_end === 1'b1, "R9 empty read keeps state", msg_end, 1);
    read_reg(2'd2, v);
    check(v == 0, "R7 status read value A", v, 0);
    check(msg_end === 1'b0, "R7 release clears end", msg_end, 0);
    check(in_ready === 1'b1, "R7 release reopens input", in_ready, 1);

    // frame B: abort and crc, early status read has no effect
    send_frame(3, 8'h20, 1'b1, 1'b1);
    idle(1);
    read_reg(2'd2, v);
    check(v == 0, "R7 early status read value", v, 0);
    check(in_ready === 1'b0, "R7 early read does not release", in_ready, 0);
    drain(3, 8'h20, 8'h03, "R5 frame B");
    read_reg(2'd2, v);
    check(v == 3, "R7 status read value B", v, 3);

    // frame C: overflow without DMA reads, crc flag on last ignored
    send_frame(20, 8'h40, 1'b0, 1'b1);
    idle(2);
    drain(DEPTH - 1, 8'h40, 8'h04, "R8 overflow frame");
    read_reg(2'd2, v);
    check(v == 4, "R8 overflow status", v, 4);

    // frame D with concurrent DMA reads
    fork
      send_frame(6, 8'h60, 1'b0, 1'b0);
      for (int k = 0; k < 10; k++) read_reg(2'd1, v);
    join
    idle(2);
    while (dma_rd_req) read_reg(2'd1, v);
    check(msg_end === 1'b1, "R6 end after concurrent frame", msg_end, 1);
    read_reg(2'd2, v);
    check(v == 0, "R5 status of frame D", v, 0);

    // R1 disable while data waits
    send_frame(2, 8'h70, 1'b0, 1'b0);
    idle(1);
    write_cfg(2'b10);
    check(dma_rd_req === 1'b0, "R1 request masked when disabled", dma_rd_req, 0);
    write_cfg(2'b11);
    check(dma_rd_req === 1'b1, "R1 request back when enabled", dma_rd_req, 1);
    drain(2, 8'h70, 8'h00, "R4 frame E");
    read_reg(2'd2, v);
    idle(3);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule